// File: doc/BRIEF.md
# Fixed-Point Rounding Multiply and Shift Unit

This block is an arithmetic stage for signed 32-bit fixed-point values that represent numbers in [-1, 1). Each accepted request carries two operands, a signed shift exponent and an operation code. The operation is one of three: a doubling multiply that keeps the rounded upper half and saturates, a rounding arithmetic right shift, or a power-of-two scale whose exponent sign picks a saturating left shift or a rounding right shift. The result is registered once and comes out one clock after the request is accepted.

Both edges of the block are valid/ready streams.
- A request moves in on a clock edge where `in_valid` and `in_ready` are both high.
- A result moves out on an edge where `out_valid` and `out_ready` are both high.
- `in_ready` is high whenever the output register is empty, or when its content leaves on the same edge. A stalled result therefore blocks new requests, but a full stream of requests runs at one per clock while `out_ready` stays high.
- A producer may hold `in_valid` high for as long as it needs. A result that is offered stays unchanged until it is taken.

Top module: `fxp_round_mul_unit`

## Requirements
- R1: With `in_op` = 0 (multiply), the full signed 64-bit product P = a*b gets a nudge of 2^30 when P >= 0, or 1 - 2^30 when P < 0. The sum is divided by 2^31 with truncation toward zero, and the low 32 bits form the result.
- R2: With `in_op` = 0, if both operands equal 0x80000000 the result is 0x7FFFFFFF.
- R3: With `in_op` = 1 (rounding right shift by e = `in_exp`, treated as signed):
  - for e from 1 to 31, take mask = 2^e - 1 and threshold = (mask >> 1) + 1 if a < 0, else (mask >> 1); the result is (a >>> e) + 1 when (a & mask) > threshold, otherwise a >>> e;
  - for e = 0 or any negative e, the result is a unchanged.
- R4: Only operand `in_a` is used by the two shift operations. `in_b` has no effect on their results.
- R5: With `in_op` = 2 (scale) and e >= 0, the threshold is T = 2^(31-e) - 1:
  - a > T gives 0x7FFFFFFF;
  - a < -T gives 0x80000000;
  - otherwise the result is the low 32 bits of a << e.
- R6: With `in_op` = 2 and e < 0, the result is the R3 rounding right shift of a by -e; e = -32 shifts by 32.
- R7: With `in_op` = 3 (reserved), the result is 0.
- R8: A request accepted on a clock edge makes `out_valid` high after that edge and the result available on `out_data`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is high whenever `out_valid` is low, and also when `out_ready` is high.
- R10: While `rst_n` is low, `out_valid` is low and no request is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request is offered |
| in_ready | output | 1 | Block can take a request this cycle |
| in_op | input | 2 | Operation: 0 multiply, 1 rounding right shift, 2 scale, 3 reserved |
| in_a | input | 32 | First operand (signed) |
| in_b | input | 32 | Second operand (signed, multiply only) |
| in_exp | input | 6 | Signed shift exponent, -32 to 31 |
| out_valid | output | 1 | Result is offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result (signed) |

## Verification
The event that can share a clock edge with a new request is the departure of the previous result. When both happen, the output register is emptied and refilled on the same edge. The bench provokes this by keeping requests coming back to back while `out_ready` is driven at random, so that accept-and-deliver edges mix with stalled edges where `in_ready` must fall.

A queue model in the bench judges every delivered word against its own 64-bit integer arithmetic, which catches a result that is lost, repeated or reordered. A separate per-edge check confirms that each accepted request is offered on the very next cycle.

// File: rtl/fxp_round_pkg.sv
package fxp_round_pkg;
  typedef enum logic [1:0] {
    OP_MUL   = 2'd0,
    OP_RSHR  = 2'd1,
    OP_SCALE = 2'd2,
    OP_RSVD  = 2'd3
  } fxp_op_e;
endpackage

// File: rtl/fxp_dbl_high_mul.sv
module fxp_dbl_high_mul #(
  parameter int W = 32
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic        [W-1:0] res
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] NUDGE_POS = {{(PW-1){1'b0}}, 1'b1} << (W - 2);
  localparam logic signed [PW-1:0] NUDGE_NEG = {{(PW-1){1'b0}}, 1'b1} - NUDGE_POS;
  localparam logic signed [PW-1:0] TRUNC_BIAS = ({{(PW-1){1'b0}}, 1'b1} << (W - 1)) - 1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] nudged;
  logic signed [PW-1:0] biased;
  logic                 both_min;
  logic                 unused_bits;

  always_comb begin
    prod   = PW'(a) * PW'(b);
    nudged = prod + (prod[PW-1] ? NUDGE_NEG : NUDGE_POS);
    // truncation toward zero: bias negative sums before the floor shift
    biased = nudged + (nudged[PW-1] ? TRUNC_BIAS : '0);
    both_min = (a == MINV) && (b == MINV);
    res = both_min ? MAXV : biased[PW-2:W-1];
  end

  assign unused_bits = ^{biased[PW-1], biased[W-2:0]};
endmodule

// File: rtl/fxp_round_rshift.sv
module fxp_round_rshift #(
  parameter int W    = 32,
  parameter int SH_W = 6
) (
  input  logic signed [W-1:0]    x,
  input  logic        [SH_W-1:0] amt,
  output logic        [W-1:0]    res
);
  logic        [W:0]   mask;
  logic        [W:0]   thresh;
  logic        [W:0]   frac;
  logic signed [W-1:0] floor_q;
  logic                bump;

  always_comb begin
    mask    = ({{W{1'b0}}, 1'b1} << amt) - 1'b1;
    thresh  = (mask >> 1) + {{W{1'b0}}, x[W-1]};
    frac    = {x[W-1], x} & mask;
    floor_q = x >>> amt;
    bump    = frac > thresh;
    res     = floor_q + {{(W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/fxp_sat_lshift.sv
module fxp_sat_lshift #(
  parameter int W    = 32,
  parameter int LS_W = 5
) (
  input  logic signed [W-1:0]    x,
  input  logic        [LS_W-1:0] amt,
  output logic        [W-1:0]    res
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic signed [W:0] limit;
  logic signed [W:0] xe;
  logic              hi_ovf;
  logic              lo_ovf;

  always_comb begin
    limit  = ({{W{1'b0}}, 1'b1} << (W - 1 - int'(amt))) - 1'sb1;
    xe     = {x[W-1], x};
    hi_ovf = xe > limit;
    lo_ovf = xe < -limit;
    if (hi_ovf)      res = MAXV;
    else if (lo_ovf) res = MINV;
    else             res = x << amt;
  end
endmodule

// File: rtl/fxp_round_mul_unit.sv
module fxp_round_mul_unit
  import fxp_round_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [EXP_W-1:0] in_exp,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data
);
  localparam int SH_W = $clog2(W) + 1;
  localparam int LS_W = $clog2(W);

  fxp_op_e          op;
  logic             exp_neg;
  logic [EXP_W-1:0] exp_mag;
  logic [SH_W-1:0]  rs_amt;
  logic [W-1:0]     mul_res;
  logic [W-1:0]     rs_res;
  logic [W-1:0]     ls_res;
  logic [W-1:0]     sel_res;

  assign op      = fxp_op_e'(in_op);
  assign exp_neg = in_exp[EXP_W-1];
  assign exp_mag = exp_neg ? (~in_exp + 1'b1) : in_exp;

  // one right shifter serves both the plain shift and the negative scale
  always_comb begin
    rs_amt = '0;
    if (op == OP_RSHR && !exp_neg)      rs_amt = SH_W'(in_exp);
    else if (op == OP_SCALE && exp_neg) rs_amt = SH_W'(exp_mag);
  end

  fxp_dbl_high_mul #(.W(W)) u_mul (
    .a   (in_a),
    .b   (in_b),
    .res (mul_res)
  );

  fxp_round_rshift #(.W(W), .SH_W(SH_W)) u_rsh (
    .x   (in_a),
    .amt (rs_amt),
    .res (rs_res)
  );

  fxp_sat_lshift #(.W(W), .LS_W(LS_W)) u_lsh (
    .x   (in_a),
    .amt (in_exp[LS_W-1:0]),
    .res (ls_res)
  );

  always_comb begin
    unique case (op)
      OP_MUL:   sel_res = mul_res;
      OP_RSHR:  sel_res = rs_res;
      OP_SCALE: sel_res = exp_neg ? rs_res : ls_res;
      default:  sel_res = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_res;
    end
  end
endmodule

// File: rtl/fxp_round_mul_unit_chk.sv
module fxp_round_mul_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  assert_minmin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'd0 && in_a == MINV && in_b == MINV)
      |=> (out_valid && out_data == MAXV));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'd3) |=> (out_valid && out_data == '0));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ready_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  always @(negedge clk) begin
    if (!rst_n) assert_idle_in_reset_R10: assert (!out_valid);
  end
endmodule

bind fxp_round_mul_unit fxp_round_mul_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/fxp_round_mul_unit_tb.sv
module fxp_round_mul_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [5:0]  in_exp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct { int val; int tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_round_mul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_exp(in_exp),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic longint rnd_shift(longint x, int e);
    longint mask, thr;
    if (e <= 0) return x;
    mask = (longint'(1) << e) - 1;
    thr  = (mask >>> 1) + ((x < 0) ? 1 : 0);
    return (x >>> e) + (((x & mask) > thr) ? 1 : 0);
  endfunction

  function automatic int model(int op, int a, int b, int e, output int tag);
    longint p, s, thr;
    case (op)
      0: begin
        if (a == 32'h8000_0000 && b == 32'h8000_0000) begin tag = 2; return 32'h7FFF_FFFF; end
        tag = 1;
        p = longint'(a) * longint'(b);
        s = p + ((p >= 0) ? (longint'(1) << 30) : (1 - (longint'(1) << 30)));
        return int'(s / (longint'(1) << 31));
      end
      1: begin tag = 3; return int'(rnd_shift(longint'(a), e)); end
      2: begin
        if (e < 0) begin tag = 6; return int'(rnd_shift(longint'(a), -e)); end
        tag = 5;
        thr = (longint'(1) << (31 - e)) - 1;
        if (longint'(a) > thr)  return 32'h7FFF_FFFF;
        if (longint'(a) < -thr) return 32'h8000_0000;
        return int'(longint'(a) << e);
      end
      default: begin tag = 7; return 0; end
    endcase
  endfunction

  function automatic string tag_name(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one clock of traffic: drive at negedge, judge handshakes, then take the edge
  bit prev_accept = 0;
  task automatic step(bit v, int op, int a, int b, int e, bit rdy);
    bit acc, dlv;
    int tag, ev;
    exp_t item;
    @(negedge clk);
    in_valid = v; in_op = 2'(op); in_a = a; in_b = b; in_exp = 6'(e); out_ready = rdy;
    if (prev_accept) check(out_valid == 1'b1, "R8", int'(out_valid), 1);
    #1;
    acc = in_valid && in_ready;
    dlv = out_valid && out_ready;
    if (!out_valid || out_ready) check(in_ready == 1'b1, "R9", int'(in_ready), 1);
    else check(in_ready == 1'b0, "R9", int'(in_ready), 0);
    if (dlv) begin
      if (q.size() == 0) check(1'b0, "R9", int'(out_data), 0);
      else begin
        item = q.pop_front();
        check(out_data == item.val, tag_name(item.tag), int'(out_data), item.val);
      end
    end
    if (acc) begin
      ev = model(op, a, b, e, tag);
      item.val = ev; item.tag = tag;
      q.push_back(item);
    end
    prev_accept = acc;
    @(posedge clk);
  endtask

  int corner_v[7] = '{32'h8000_0000, 32'h7FFF_FFFF, 0, 1, -1, 32'h4000_0000, 32'hC000_0001};
  int corner_e[8] = '{-32, -31, -1, 0, 1, 2, 30, 31};

  initial begin
    // reset state (R10)
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);
    rst_n = 1'b1;

    // multiply corners (R1, R2)
    foreach (corner_v[i]) foreach (corner_v[j])
      step(1'b1, 0, corner_v[i], corner_v[j], 0, 1'b1);

    // shift corners; in_b varied to show it has no effect (R4)
    foreach (corner_v[i]) foreach (corner_e[k]) begin
      step(1'b1, 1, corner_v[i], 0, corner_e[k], 1'b1);
      step(1'b1, 1, corner_v[i], 32'h5A5A_5A5A, corner_e[k], 1'b1);
      step(1'b1, 2, corner_v[i], 0, corner_e[k], 1'b1);
      step(1'b1, 2, corner_v[i], -1, corner_e[k], 1'b1);
      step(1'b1, 3, corner_v[i], corner_v[i], corner_e[k], 1'b1);
    end

    // rounding ties: half-way values, positive and negative (R3, R6)
    for (int e = 1; e < 6; e++) begin
      step(1'b1, 1, 1 << (e - 1), 0, e, 1'b1);
      step(1'b1, 1, -(1 << (e - 1)), 0, e, 1'b1);
      step(1'b1, 2, 3 << (e - 1), 0, -e, 1'b1);
      step(1'b1, 2, -(3 << (e - 1)), 0, -e, 1'b1);
    end

    // random mix with back-pressure (R8, R9)
    for (int n = 0; n < N_RANDOM; n++) begin
      int a, b;
      a = int'($urandom());
      b = int'($urandom());
      if ($urandom_range(0, 7) == 0) a = corner_v[$urandom_range(0, 6)];
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 3)), a, b,
           int'($signed(6'($urandom_range(0, 63)))), $urandom_range(0, 2) != 0);
    end

    // drain
    for (int n = 0; n < 4; n++) step(1'b0, 0, 0, 0, 0, 1'b1);
    check(q.size() == 0, "R9", q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule